// File: doc/BRIEF.md
# Frame Buffer Burst Fetch Engine

This engine moves one frame of tightly packed 24-bit pixels from external memory into an on-chip pixel FIFO. It sits between a burst-read master port and the write side of that FIFO. The frame is stored as a contiguous byte array of width × height × 3 bytes, starting at a programmed base address. The engine reads it in raster order, in bus words. Pixels straddle word boundaries freely, so the engine counts words, not pixels or lines.

A processor programs the base address, the image width, the image height and an enable bit through a small register write port. Fetching starts on the next start-of-frame pulse. It restarts from the base address on every later pulse. A burst is requested only when the FIFO can take a whole maximum-length burst. The final burst of a frame is shortened to the words that remain. The engine also raises a sticky flag if the FIFO runs dry while the display is drawing visible pixels.

Top module: `frame_fetch`

## Requirements
- R1: After reset, `rd_req`, `fifo_wr` and `underrun` are all 0.
- R2: Setting the enable bit alone starts no transfer. The first request after a start-of-frame pulse carries the programmed base address. Register selects: 0 = base, 1 = width (low DIM_W bits), 2 = height (low DIM_W bits), 3 = control (bit 0 = enable).
- R3: A request is raised only when FIFO_WORDS − `fifo_level` ≥ BURST. When the FIFO is full, fetching stalls and then resumes once the FIFO drains.
- R4: Every burst has BURST words, except the last burst of a frame, which carries the remaining words. A frame totals ceil(width × height × 3 / bytes-per-word) words.
- R5: Burst addresses are contiguous. Each one equals the previous address plus the previous length × bytes-per-word, so the FIFO receives memory words in ascending order.
- R6: Each `rd_valid` beat of an accepted burst appears as one `fifo_wr` with the same data, in order.
- R7: While `rd_req` is high and `rd_ack` is low, the request, `rd_addr` and `rd_len` stay unchanged. Only one burst is outstanding at a time.
- R8: Once a frame's word count is reached, no request is made until the next start-of-frame pulse. That pulse fetches the frame again from the base address.
- R9: Clearing enable lets an accepted burst finish and issues no further requests. The remaining count is dropped, so re-enabling without a start-of-frame pulse fetches nothing.
- R10: `underrun` is set when `fifo_empty` and `active_video` are both high while enabled. It holds until a write to the control register.
- R11: An `rd_valid` beat outside an accepted burst produces no FIFO write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| sof | input | 1 | Start-of-frame pulse |
| active_video | input | 1 | Display is in visible area |
| fifo_level | input | LVL_W | Words held in the pixel FIFO |
| fifo_empty | input | 1 | Pixel FIFO is empty |
| fifo_wr | output | 1 | Pixel FIFO write strobe |
| fifo_wdata | output | DW | Pixel FIFO write data |
| rd_req | output | 1 | Burst read request |
| rd_addr | output | AW | Burst byte address |
| rd_len | output | LEN_W | Burst length in words |
| rd_ack | input | 1 | Request accepted |
| rd_valid | input | 1 | Read data beat valid |
| rd_data | input | DW | Read data beat |
| underrun | output | 1 | Sticky FIFO underrun flag |

## Verification
The bound checker watches four things on every cycle:
- free space whenever a request rises;
- the stability of a pending request;
- the legal range of burst lengths;
- the absence of FIFO writes while a request is pending, and the stickiness of the underrun flag.

Other behaviour spans whole frames, and only the bench scenarios show it:
- word order and frame totals, including shortened last bursts;
- the stall at a full FIFO and the restart after draining;
- the reload on a new start-of-frame pulse;
- the abort on enable clear, with its lost count.

// File: rtl/ffe_pkg.sv
package ffe_pkg;
  typedef enum logic [1:0] {
    FS_WAIT = 2'd0,
    FS_REQ  = 2'd1,
    FS_BEAT = 2'd2
  } fetch_st_e;

  localparam logic [1:0] SEL_BASE   = 2'd0;
  localparam logic [1:0] SEL_WIDTH  = 2'd1;
  localparam logic [1:0] SEL_HEIGHT = 2'd2;
  localparam logic [1:0] SEL_CTRL   = 2'd3;
endpackage

// File: rtl/ffe_regs.sv
module ffe_regs #(
  parameter int AW    = 32,
  parameter int DIM_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       sel,
  input  logic [31:0]      wdata,
  output logic [AW-1:0]    base_o,
  output logic [DIM_W-1:0] width_o,
  output logic [DIM_W-1:0] height_o,
  output logic             en_o,
  output logic             ctrl_wr_o
);
  import ffe_pkg::*;

  logic [AW-1:0]    base_q;
  logic [DIM_W-1:0] width_q, height_q;
  logic             en_q;
  logic             base_ce, width_ce, height_ce, ctrl_ce;
  logic             unused_hi;

  assign unused_hi = ^wdata;
  assign base_ce   = we && (sel == SEL_BASE);
  assign width_ce  = we && (sel == SEL_WIDTH);
  assign height_ce = we && (sel == SEL_HEIGHT);
  assign ctrl_ce   = we && (sel == SEL_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      width_q  <= '0;
      height_q <= '0;
      en_q     <= 1'b0;
    end else begin
      if (base_ce)   base_q   <= wdata[AW-1:0];
      if (width_ce)  width_q  <= wdata[DIM_W-1:0];
      if (height_ce) height_q <= wdata[DIM_W-1:0];
      if (ctrl_ce)   en_q     <= wdata[0];
    end
  end

  assign base_o    = base_q;
  assign width_o   = width_q;
  assign height_o  = height_q;
  assign en_o      = en_q;
  assign ctrl_wr_o = ctrl_ce;
endmodule

// File: rtl/ffe_size.sv
module ffe_size #(
  parameter int DIM_W   = 12,
  parameter int BPW_LOG = 2,
  parameter int CNT_W   = 2*DIM_W + 2
) (
  input  logic [DIM_W-1:0] width_i,
  input  logic [DIM_W-1:0] height_i,
  output logic [CNT_W-1:0] words_o
);
  localparam int BPW = 1 << BPW_LOG;

  logic [CNT_W-1:0] bytes;

  assign bytes   = CNT_W'(width_i) * CNT_W'(height_i) * CNT_W'(3);
  assign words_o = (bytes + CNT_W'(BPW - 1)) >> BPW_LOG;
endmodule

// File: rtl/ffe_seq.sv
module ffe_seq #(
  parameter int AW         = 32,
  parameter int BPW_LOG    = 2,
  parameter int BURST      = 8,
  parameter int FIFO_WORDS = 64,
  parameter int CNT_W      = 26,
  parameter int LVL_W      = 7,
  parameter int LEN_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             sof,
  input  logic [AW-1:0]    base,
  input  logic [CNT_W-1:0] total_words,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             rd_ack,
  input  logic             rd_valid,
  output logic             rd_req,
  output logic [AW-1:0]    rd_addr,
  output logic [LEN_W-1:0] rd_len,
  output logic             beat_ok
);
  import ffe_pkg::*;

  fetch_st_e        state_q, state_d;
  logic [AW-1:0]    addr_q, addr_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic [LEN_W-1:0] len_q, len_d, beat_q, beat_d, next_len;
  logic             pend_q, pend_d;
  logic             room;

  assign room = ({1'b0, fifo_level} + (LVL_W+1)'(BURST)) <= (LVL_W+1)'(FIFO_WORDS);
  assign next_len = (left_q >= CNT_W'(BURST)) ? LEN_W'(BURST) : left_q[LEN_W-1:0];

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    left_d  = left_q;
    len_d   = len_q;
    beat_d  = beat_q;
    pend_d  = en && (pend_q || sof);
    case (state_q)
      FS_WAIT: begin
        if (!en) begin
          left_d = '0;
        end else if (pend_q) begin
          addr_d = base;
          left_d = total_words;
          pend_d = sof;
        end else if ((left_q != '0) && room) begin
          len_d   = next_len;
          beat_d  = '0;
          state_d = FS_REQ;
        end
      end
      FS_REQ: begin
        if (rd_ack) state_d = FS_BEAT;
      end
      FS_BEAT: begin
        if (rd_valid) begin
          beat_d = beat_q + LEN_W'(1);
          if (beat_q == len_q - LEN_W'(1)) begin
            state_d = FS_WAIT;
            addr_d  = addr_q + (AW'(len_q) << BPW_LOG);
            left_d  = left_q - CNT_W'(len_q);
          end
        end
      end
      default: state_d = FS_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_WAIT;
      addr_q  <= '0;
      left_q  <= '0;
      len_q   <= '0;
      beat_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      left_q  <= left_d;
      len_q   <= len_d;
      beat_q  <= beat_d;
      pend_q  <= pend_d;
    end
  end

  assign rd_req  = (state_q == FS_REQ);
  assign rd_addr = addr_q;
  assign rd_len  = len_q;
  assign beat_ok = (state_q == FS_BEAT);
endmodule

// File: rtl/ffe_underrun.sv
module ffe_underrun (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic active_video,
  input  logic fifo_empty,
  input  logic clear,
  output logic flag
);
  logic flag_q, flag_d;

  always_comb begin
    if (clear)                                flag_d = 1'b0;
    else if (en && active_video && fifo_empty) flag_d = 1'b1;
    else                                      flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/frame_fetch.sv
module frame_fetch #(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int FIFO_BYTES = 256,
  parameter int BURST      = 8,
  parameter int DIM_W      = 12,
  localparam int BPW        = DW / 8,
  localparam int BPW_LOG    = $clog2(BPW),
  localparam int FIFO_WORDS = FIFO_BYTES / BPW,
  localparam int LVL_W      = $clog2(FIFO_WORDS + 1),
  localparam int LEN_W      = $clog2(BURST + 1),
  localparam int CNT_W      = 2*DIM_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [31:0]      cfg_wdata,
  input  logic             sof,
  input  logic             active_video,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             fifo_empty,
  output logic             fifo_wr,
  output logic [DW-1:0]    fifo_wdata,
  output logic             rd_req,
  output logic [AW-1:0]    rd_addr,
  output logic [LEN_W-1:0] rd_len,
  input  logic             rd_ack,
  input  logic             rd_valid,
  input  logic [DW-1:0]    rd_data,
  output logic             underrun
);
  logic [AW-1:0]    base;
  logic [DIM_W-1:0] width, height;
  logic             en, ctrl_wr, beat_ok;
  logic [CNT_W-1:0] total_words;

  ffe_regs #(.AW(AW), .DIM_W(DIM_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .base_o(base), .width_o(width), .height_o(height), .en_o(en), .ctrl_wr_o(ctrl_wr)
  );

  ffe_size #(.DIM_W(DIM_W), .BPW_LOG(BPW_LOG), .CNT_W(CNT_W)) u_size (
    .width_i(width), .height_i(height), .words_o(total_words)
  );

  ffe_seq #(
    .AW(AW), .BPW_LOG(BPW_LOG), .BURST(BURST), .FIFO_WORDS(FIFO_WORDS),
    .CNT_W(CNT_W), .LVL_W(LVL_W), .LEN_W(LEN_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .sof(sof), .base(base),
    .total_words(total_words), .fifo_level(fifo_level), .rd_ack(rd_ack),
    .rd_valid(rd_valid), .rd_req(rd_req), .rd_addr(rd_addr), .rd_len(rd_len),
    .beat_ok(beat_ok)
  );

  ffe_underrun u_urun (
    .clk(clk), .rst_n(rst_n), .en(en), .active_video(active_video),
    .fifo_empty(fifo_empty), .clear(ctrl_wr), .flag(underrun)
  );

  assign fifo_wr    = beat_ok && rd_valid;
  assign fifo_wdata = rd_data;
endmodule

// File: rtl/ffe_checker.sv
module ffe_checker #(
  parameter int AW         = 32,
  parameter int BURST      = 8,
  parameter int FIFO_WORDS = 64,
  parameter int LVL_W      = 7,
  parameter int LEN_W      = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [1:0]       cfg_sel,
  input logic [LVL_W-1:0] fifo_level,
  input logic             fifo_wr,
  input logic             rd_req,
  input logic [AW-1:0]    rd_addr,
  input logic [LEN_W-1:0] rd_len,
  input logic             rd_ack,
  input logic             underrun
);
  AST_ROOM_ON_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req) |-> (({1'b0, fifo_level} + (LVL_W+1)'(BURST)) <= (LVL_W+1)'(FIFO_WORDS))); // R3

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr) && $stable(rd_len))); // R7

  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> ((rd_len != '0) && (rd_len <= LEN_W'(BURST)))); // R4

  AST_NO_WR_WHILE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> !fifo_wr); // R11

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !(cfg_we && cfg_sel == 2'd3)) |=> underrun); // R10
endmodule

bind frame_fetch ffe_checker #(
  .AW(AW), .BURST(BURST), .FIFO_WORDS(FIFO_WORDS), .LVL_W(LVL_W), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .fifo_level(fifo_level), .fifo_wr(fifo_wr), .rd_req(rd_req), .rd_addr(rd_addr),
  .rd_len(rd_len), .rd_ack(rd_ack), .underrun(underrun)
);

// File: tb/frame_fetch_test.sv
module frame_fetch_test;
  localparam int FW = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic        sof = 1'b0, active_video = 1'b0;
  logic [6:0]  fifo_level;
  logic        fifo_empty, fifo_wr, rd_req, rd_ack, rd_valid, underrun;
  logic        slv_valid, stray_valid = 1'b0, drain_en = 1'b1, tick;
  logic [31:0] fifo_wdata, rd_addr, rd_data;
  logic [3:0]  rd_len;

  int nchk = 0, nfail = 0, wr_count = 0, bursts = 0;
  bit req_prev = 1'b0;
  logic [31:0] expq[$];

  always #2.5 clk = ~clk;

  frame_fetch uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .sof(sof), .active_video(active_video), .fifo_level(fifo_level), .fifo_empty(fifo_empty),
    .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_len(rd_len), .rd_ack(rd_ack), .rd_valid(rd_valid), .rd_data(rd_data), .underrun(underrun)
  );

  assign rd_valid   = slv_valid | stray_valid;
  assign fifo_empty = (fifo_level == 7'd0);

  function automatic logic [31:0] mem_word(logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h00A5_5A00;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // FIFO occupancy model: writes from the engine, slow drain from the display side
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_level <= '0;
      tick <= 1'b0;
    end else begin
      tick <= ~tick;
      fifo_level <= fifo_level + 7'(fifo_wr) - 7'(drain_en && tick && fifo_level != 0);
    end
  end

  // Memory slave: accept a request, then return beats with occasional gaps
  initial begin
    rd_ack = 1'b0; slv_valid = 1'b0; rd_data = '0;
    forever begin
      @(negedge clk);
      if (rd_req === 1'b1) begin
        automatic logic [31:0] a = rd_addr;
        automatic int n = int'(rd_len);
        @(posedge clk); #1 rd_ack = 1'b1;
        @(posedge clk); #1 rd_ack = 1'b0;
        for (int i = 0; i < n; i++) begin
          slv_valid = 1'b1;
          rd_data = mem_word(a + 32'(i*4));
          @(posedge clk); #1 slv_valid = 1'b0;
          if (i % 3 == 1) begin @(posedge clk); #1; end
        end
      end
    end
  end

  // Monitor: scoreboard pop/compare and request checks
  always @(negedge clk) begin
    if (rst_n) begin
      if (fifo_wr) begin
        wr_count++;
        if (expq.size() == 0) chk(1'b0, "R6 unexpected FIFO write", fifo_wdata, 0);
        else begin
          automatic logic [31:0] e = expq.pop_front();
          chk(fifo_wdata == e, "R5/R6 FIFO word order", fifo_wdata, e);
        end
      end
      if (rd_req && !req_prev) begin
        bursts++;
        chk(FW - int'(fifo_level) >= 8, "R3 room at request", fifo_level, FW - 8);
        chk(rd_len >= 1 && rd_len <= 8, "R4 burst length range", rd_len, 8);
      end
      req_prev <= rd_req;
    end
  end

  task automatic wr_reg(logic [1:0] s, logic [31:0] d);
    @(posedge clk); #1 cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(posedge clk); #1 cfg_we = 1'b0;
  endtask

  task automatic pulse_sof();
    @(posedge clk); #1 sof = 1'b1;
    @(posedge clk); #1 sof = 1'b0;
  endtask

  task automatic load_frame(logic [31:0] base, int w, int h);
    automatic int tot = (w*h*3 + 3) / 4;
    wr_reg(2'd0, base); wr_reg(2'd1, 32'(w)); wr_reg(2'd2, 32'(h));
    for (int k = 0; k < tot; k++) expq.push_back(mem_word(base + 32'(k*4)));
  endtask

  task automatic wait_drained();
    while (expq.size() != 0) @(negedge clk);
    repeat (30) @(negedge clk);
  endtask

  task automatic run_frame(logic [31:0] base, int w, int h, string tag);
    automatic int w0 = wr_count;
    automatic int tot = (w*h*3 + 3) / 4;
    load_frame(base, w, h);
    pulse_sof();
    wait_drained();
    chk(wr_count - w0 == tot, tag, wr_count - w0, tot);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(rd_req == 1'b0, "R1 rd_req after reset", rd_req, 0);
    chk(fifo_wr == 1'b0, "R1 fifo_wr after reset", fifo_wr, 0);
    chk(underrun == 1'b0, "R1 underrun after reset", underrun, 0);

    // R2: enable without start-of-frame does nothing
    wr_reg(2'd0, 32'h1000); wr_reg(2'd1, 32'd10); wr_reg(2'd2, 32'd7);
    wr_reg(2'd3, 32'd1);
    repeat (50) @(negedge clk);
    chk(bursts == 0, "R2 no request before sof", bursts, 0);

    // R2 R4 R5: 10x7 frame = 210 bytes = 53 words, last burst 5 words
    run_frame(32'h1000, 10, 7, "R4 frame word total 10x7");
    chk(bursts == 7, "R4 burst count 10x7", bursts, 7);

    // R8: quiet after frame end
    begin
      automatic int b0 = bursts;
      repeat (100) @(negedge clk);
      chk(bursts == b0, "R8 no request after frame end", bursts, b0);
    end

    // R8: new sof reloads from base
    run_frame(32'h1000, 10, 7, "R8 refetch from base");

    // R4: one pixel = 3 bytes = 1 word
    run_frame(32'h0300, 1, 1, "R4 single word frame");

    // R11: stray beats while idle
    begin
      automatic int w0 = wr_count;
      @(posedge clk); #1 stray_valid = 1'b1;
      repeat (3) @(posedge clk); #1 stray_valid = 1'b0;
      repeat (5) @(negedge clk);
      chk(wr_count == w0, "R11 stray beats ignored", wr_count, w0);
    end

    // R3: stall on full FIFO, 20x5 = 75 words
    while (fifo_level != 0) @(negedge clk);
    drain_en = 1'b0;
    begin
      automatic int w0 = wr_count;
      load_frame(32'h2000, 20, 5);
      pulse_sof();
      repeat (300) @(negedge clk);
      chk(fifo_level == 7'd64, "R3 fifo filled then stall", fifo_level, 64);
      chk(wr_count - w0 == 64, "R3 words before stall", wr_count - w0, 64);
      @(posedge clk); #1 drain_en = 1'b1;
      wait_drained();
      chk(wr_count - w0 == 75, "R3 resume after drain", wr_count - w0, 75);
    end

    // R9: abort a large frame mid-burst
    begin
      automatic int w0 = wr_count;
      automatic int b0;
      load_frame(32'h8000, 100, 100);
      pulse_sof();
      while (!fifo_wr) @(negedge clk);
      @(posedge clk); #1 cfg_we = 1'b1; cfg_sel = 2'd3; cfg_wdata = 32'd0;
      @(posedge clk); #1 cfg_we = 1'b0;
      repeat (100) @(negedge clk);
      chk((wr_count - w0) % 8 == 0 && wr_count > w0, "R9 outstanding burst completed",
          wr_count - w0, 8);
      b0 = bursts;
      wr_reg(2'd3, 32'd1);
      repeat (100) @(negedge clk);
      chk(bursts == b0, "R9 count dropped on disable", bursts, b0);
      expq.delete();
    end

    // R10: underrun sticky behaviour
    while (fifo_level != 0) @(negedge clk);
    chk(underrun == 1'b0, "R10 no flag without active video", underrun, 0);
    @(posedge clk); #1 active_video = 1'b1;
    repeat (3) @(posedge clk); #1 active_video = 1'b0;
    @(negedge clk);
    chk(underrun == 1'b1, "R10 flag set on empty in active video", underrun, 1);
    repeat (10) @(negedge clk);
    chk(underrun == 1'b1, "R10 flag sticky", underrun, 1);
    wr_reg(2'd3, 32'd1);
    @(negedge clk);
    chk(underrun == 1'b0, "R10 flag cleared by control write", underrun, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule